// File: doc/BRIEF.md
# Performance Counter Register Bank

This block is the register file and counting datapath of a small performance monitoring unit. Software reaches it through a coprocessor-style index made of four fields: a primary register number, a secondary register number, and two opcode fields. A valid strobe, a write flag, a 64-bit write data bus and a width flag that marks a paired 64-bit access complete the access port. A parameterised number of 32-bit event counters advance on per-counter event pulses or on software increments. A 64-bit cycle counter advances on every clock, or once every 2^DIV_LOG2 clocks when the divider is on. Each counter raises a sticky overflow flag when it wraps, and an interrupt line combines those flags with a per-counter interrupt mask.

Count enables, interrupt enables and overflow flags each have a set view and a clear view. Writing a 1 to a bit of a set view sets that bit, and writing a 1 to a bit of a clear view clears it. Writing 0 leaves the bit alone. Either view reads back the current state. An event counter can be reached two ways: indirectly, through a counter-select register and two steered windows, or directly, through an index computed from the counter number. Privilege checks and event filtering are left to neighbouring logic.

Top module: `pmu_regbank`

## Requirements
- R1: After reset, all of the following read 0: the control fields, the enable and status maps, the user-enable bits, the filter bits and every counter. The control register reads NCNT in bits [15:11], and ovf_irq is low.
- R2: Bit n < NCNT of the count-enable and interrupt-enable maps belongs to event counter n, and bit 31 belongs to the cycle counter. Set views are at (9,12,1) and (9,14,1), and clear views are at (9,12,2) and (9,14,2); the index is written (primary, secondary, second opcode). The maps follow the set/clear rules above. Bits of counters that do not exist read 0.
- R3: A wrap to zero sets the counter's overflow flag. This flag uses the same bit positions as R2. The flags are cleared through (9,12,3) and set through (9,14,3), and both views read the same storage. If hardware sets a flag in the cycle where software clears it, the flag ends up set. ovf_irq is high while any flag and its interrupt-enable bit are both 1.
- R4: An event pulse on evt_pulse[n] adds one to counter n at the clock edge, but only when control bit 0 (global enable) and count-enable bit n are both 1. Otherwise the counter holds.
- R5: Writing (9,12,4) with bit n set adds one to counter n under the same enable condition, and this adds to an event pulse in the same cycle. A read of that address returns 0.
- R6: The counter-select register is at (9,12,5), in bits [4:0]. The selected counter's type register is at (9,13,1), and its value is at (9,13,2).
- R7: Direct access to counter n uses primary 14, secondary 8+n[4:3] and second opcode n[2:0]. Type registers use secondaries 12 to 15 in the same pattern. (14,15,7) is the cycle filter register.
- R8: A counter number at or above NCNT reads 0 and ignores writes, whether it is reached directly or indirectly.
- R9: The cycle counter is at (9,13,0). A 32-bit access reads bits [31:0] zero-extended and writes only bits [31:0]. A paired access (acc_wide=1) reads and writes all 64 bits.
- R10: The cycle counter counts when control bit 0 and enable bit 31 are both 1. If control bit 3 (divider) is set, it counts once every 2^DIV_LOG2 enabled cycles. A 64-bit wrap sets overflow flag 31.
- R11: In the control register, bit 0 is the enable, bits 3, 4 and 5 are plain stored bits, and bits [15:11] are read-only. Writing 1 to bit 1 zeroes all event counters. Writing 1 to bit 2 zeroes the cycle counter and its prescaler. Bits 1 and 2 read as 0.
- R12: The filter register keeps only bits [31:26]. The user-enable register at (9,14,0) keeps bits [3:0]: general access, software increment, cycle read, event read. Type registers keep TYPE_W low bits.
- R13: A nonzero first opcode, or an unmapped index, reads 0 and ignores writes. The identification words at (9,12,6) and (9,12,7) read as parameters CEID0 and CEID1. rd_data is 0 unless a read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | Paired 64-bit access (cycle counter only) |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Second opcode field |
| acc_op1 | input | 3 | First opcode field, must be 0 |
| acc_wdata | input | 64 | Write data |
| evt_pulse | input | NCNT | One pulse per counter per cycle |
| rd_data | output | 64 | Read data, valid in the strobe cycle |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
Reads are combinational. The bench presents a read at a falling edge and samples rd_data shortly after, in the same cycle. A write, increment or pulse takes effect at the next rising edge. The overflow flag and ovf_irq follow at that same edge, so every check after a write samples one time step past that edge. For counting windows, the bench counts the rising edges during which the enable is registered high. An enable written at edge A and removed by a write committed at edge A+K+1 gives K+1 enabled edges. With the divider on, the increments are the multiples of 2^DIV_LOG2 inside that window.

// File: rtl/pmu_pkg.sv
// Shared types and field positions for the performance counter register bank.
// Assumes at most 31 event counters so that index 31 of every map is free for the cycle counter.
package pmu_pkg;

    typedef enum logic [4:0] {
        RK_NONE,
        RK_CTRL,
        RK_CNTSET,
        RK_CNTCLR,
        RK_OVSCLR,
        RK_SWINC,
        RK_SEL,
        RK_CEID0,
        RK_CEID1,
        RK_CCNT,
        RK_EVCNT,
        RK_EVTYP,
        RK_UEN,
        RK_INTSET,
        RK_INTCLR,
        RK_OVSSET,
        RK_FILT
    } reg_kind_e;

    localparam int CTL_EN  = 0;
    localparam int CTL_EVR = 1;
    localparam int CTL_CYR = 2;
    localparam int CTL_DIV = 3;
    localparam int CTL_EXP = 4;
    localparam int CTL_DPR = 5;
    localparam int CYC_BIT = 31;

endpackage

// File: rtl/pmu_decode.sv
// Index decoder: turns the coprocessor-style index into a register kind and a counter number.
// Assumes the counter-select value is already registered; indirect windows take their number from it.
module pmu_decode
    import pmu_pkg::*;
(
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic [2:0] op1,
    input  logic [4:0] sel,
    output reg_kind_e  kind,
    output logic [4:0] idx
);

    logic [4:0] direct_idx;

    assign direct_idx = {crm[1:0], op2};

    // Map each index onto a register kind; anything unlisted is RK_NONE.
    always_comb begin
        kind = RK_NONE;
        idx  = 5'd0;
        if (op1 == 3'd0) begin
            if (crn == 4'd9) begin
                case (crm)
                    4'd12: begin
                        case (op2)
                            3'd0:    kind = RK_CTRL;
                            3'd1:    kind = RK_CNTSET;
                            3'd2:    kind = RK_CNTCLR;
                            3'd3:    kind = RK_OVSCLR;
                            3'd4:    kind = RK_SWINC;
                            3'd5:    kind = RK_SEL;
                            3'd6:    kind = RK_CEID0;
                            default: kind = RK_CEID1;
                        endcase
                    end
                    4'd13: begin
                        case (op2)
                            3'd0: kind = RK_CCNT;
                            3'd1: begin kind = RK_EVTYP; idx = sel; end
                            3'd2: begin kind = RK_EVCNT; idx = sel; end
                            default: kind = RK_NONE;
                        endcase
                    end
                    4'd14: begin
                        case (op2)
                            3'd0:    kind = RK_UEN;
                            3'd1:    kind = RK_INTSET;
                            3'd2:    kind = RK_INTCLR;
                            3'd3:    kind = RK_OVSSET;
                            default: kind = RK_NONE;
                        endcase
                    end
                    default: kind = RK_NONE;
                endcase
            end else if (crn == 4'd14 && crm[3]) begin
                idx = direct_idx;
                if (!crm[2]) begin
                    kind = (direct_idx == 5'd31) ? RK_NONE : RK_EVCNT;
                end else begin
                    kind = (direct_idx == 5'd31) ? RK_FILT : RK_EVTYP;
                end
            end
        end
    end

endmodule

// File: rtl/pmu_evcnt_bank.sv
// Bank of 32-bit event counters with their type registers.
// Priority per counter: software write, then bulk reset, then increment (pulse plus software step).
// Assumes inc_en already folds in the global enable and the per-counter enable.
module pmu_evcnt_bank #(
    parameter int NCNT   = 6,
    parameter int TYPE_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCNT-1:0]        cnt_we,
    input  logic [NCNT-1:0]        typ_we,
    input  logic [31:0]            wdata,
    input  logic [TYPE_W-1:0]      wtype,
    input  logic                   clr_all,
    input  logic [NCNT-1:0]        inc_en,
    input  logic [NCNT-1:0]        evt,
    input  logic [NCNT-1:0]        sw,
    output logic [NCNT*32-1:0]     cnt_flat,
    output logic [NCNT*TYPE_W-1:0] typ_flat,
    output logic [NCNT-1:0]        wrap
);

    for (genvar n = 0; n < NCNT; n++) begin : g_cnt
        logic [31:0]       cnt_q;
        logic [TYPE_W-1:0] typ_q;
        logic [1:0]        step;
        logic [32:0]       sum;

        // Work out this counter's step and the carry out of bit 31.
        always_comb begin
            step    = {1'b0, evt[n] & inc_en[n]} + {1'b0, sw[n] & inc_en[n]};
            sum     = {1'b0, cnt_q} + {31'd0, step};
            wrap[n] = sum[32] && !cnt_we[n] && !clr_all;
        end

        // Update the counter value.
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q <= '0;
            else if (cnt_we[n])  cnt_q <= wdata;
            else if (clr_all)    cnt_q <= '0;
            else                 cnt_q <= sum[31:0];
        end

        // Hold the event type for this counter.
        always_ff @(posedge clk) begin
            if (!rst_n)          typ_q <= '0;
            else if (typ_we[n])  typ_q <= wtype;
        end

        assign cnt_flat[n*32 +: 32]         = cnt_q;
        assign typ_flat[n*TYPE_W +: TYPE_W] = typ_q;
    end

endmodule

// File: rtl/pmu_cyccnt.sv
// 64-bit cycle counter with an optional power-of-two prescaler.
// Halves are written separately so a 32-bit write leaves the upper half alone.
// Assumes run already folds in the global enable and enable bit 31.
module pmu_cyccnt #(
    parameter int DIV_LOG2 = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        div_en,
    input  logic        clr,
    input  logic        we_lo,
    input  logic        we_hi,
    input  logic [63:0] wdata,
    output logic [63:0] cnt,
    output logic        wrap
);

    logic [DIV_LOG2-1:0] presc_q;
    logic [63:0]         cnt_q;
    logic                tick;

    assign tick = run && (!div_en || (presc_q == '1));
    assign wrap = tick && (cnt_q == '1) && !we_lo && !clr;
    assign cnt  = cnt_q;

    // Advance the prescaler while dividing.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         presc_q <= '0;
        else if (run && div_en)    presc_q <= presc_q + 1'b1;
    end

    // Update the 64-bit count; a write to either half wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (we_lo) begin
            cnt_q[31:0]  <= wdata[31:0];
            cnt_q[63:32] <= we_hi ? wdata[63:32] : cnt_q[63:32];
        end else if (tick) begin
            cnt_q <= cnt_q + 64'd1;
        end
    end

endmodule

// File: rtl/pmu_regbank.sv
// Top of the performance counter register bank: control, enable and status maps, the counter
// select, the software increment port and the read multiplexer around the counter datapaths.
// Assumes one access per cycle; reads are combinational and writes land on the next edge.
module pmu_regbank
    import pmu_pkg::*;
#(
    parameter int          NCNT     = 6,
    parameter int          TYPE_W   = 10,
    parameter int          DIV_LOG2 = 6,
    parameter logic [31:0] CEID0    = 32'h6000_1F3B,
    parameter logic [31:0] CEID1    = 32'h0000_00A5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic            acc_wide,
    input  logic [3:0]      acc_crn,
    input  logic [3:0]      acc_crm,
    input  logic [2:0]      acc_op2,
    input  logic [2:0]      acc_op1,
    input  logic [63:0]     acc_wdata,
    input  logic [NCNT-1:0] evt_pulse,
    output logic [63:0]     rd_data,
    output logic            ovf_irq
);

    localparam logic [31:0] MAP_MASK = 32'h8000_0000 | ((32'd1 << NCNT) - 32'd1);
    localparam logic [4:0]  NCNT5    = 5'(NCNT);

    reg_kind_e             rk;
    logic [4:0]            ri;
    logic                  wr;
    logic                  in_range;
    logic [31:0]           w32;

    logic                  ctrl_e, ctrl_d, ctrl_x, ctrl_dp;
    logic [31:0]           cnten, inten, ovs;
    logic [4:0]            sel_q;
    logic [3:0]            uen_q;
    logic [5:0]            filt_q;

    logic [NCNT-1:0]       cnt_we, typ_we, ev_wrap, sw_vec, inc_en;
    logic [NCNT*32-1:0]    cnt_flat;
    logic [NCNT*TYPE_W-1:0] typ_flat;
    logic [63:0]           ccnt;
    logic                  cyc_wrap;
    logic [31:0]           hw_ovf;
    logic [31:0]           cnt_arr [32];
    logic [31:0]           typ_arr [32];
    logic [63:0]           rmux;

    pmu_decode u_dec (
        .crn  (acc_crn),
        .crm  (acc_crm),
        .op2  (acc_op2),
        .op1  (acc_op1),
        .sel  (sel_q),
        .kind (rk),
        .idx  (ri)
    );

    assign wr       = acc_valid && acc_write;
    assign w32      = acc_wdata[31:0];
    assign in_range = int'(ri) < NCNT;

    // Steer counter and type writes to a single counter.
    always_comb begin
        cnt_we = (wr && rk == RK_EVCNT && in_range) ? (NCNT'(1) << ri) : '0;
        typ_we = (wr && rk == RK_EVTYP && in_range) ? (NCNT'(1) << ri) : '0;
        sw_vec = (wr && rk == RK_SWINC) ? w32[NCNT-1:0] : '0;
        inc_en = {NCNT{ctrl_e}} & cnten[NCNT-1:0];
    end

    pmu_evcnt_bank #(.NCNT(NCNT), .TYPE_W(TYPE_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_we   (cnt_we),
        .typ_we   (typ_we),
        .wdata    (w32),
        .wtype    (w32[TYPE_W-1:0]),
        .clr_all  (wr && rk == RK_CTRL && w32[CTL_EVR]),
        .inc_en   (inc_en),
        .evt      (evt_pulse),
        .sw       (sw_vec),
        .cnt_flat (cnt_flat),
        .typ_flat (typ_flat),
        .wrap     (ev_wrap)
    );

    pmu_cyccnt #(.DIV_LOG2(DIV_LOG2)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_e && cnten[CYC_BIT]),
        .div_en (ctrl_d),
        .clr    (wr && rk == RK_CTRL && w32[CTL_CYR]),
        .we_lo  (wr && rk == RK_CCNT),
        .we_hi  (wr && rk == RK_CCNT && acc_wide),
        .wdata  (acc_wdata),
        .cnt    (ccnt),
        .wrap   (cyc_wrap)
    );

    // Spread the flat counter buses onto 32-entry arrays, zero past NCNT.
    for (genvar n = 0; n < 32; n++) begin : g_arr
        if (n < NCNT) begin : g_live
            assign cnt_arr[n] = cnt_flat[n*32 +: 32];
            assign typ_arr[n] = 32'(typ_flat[n*TYPE_W +: TYPE_W]);
        end else begin : g_zero
            assign cnt_arr[n] = '0;
            assign typ_arr[n] = '0;
        end
    end

    // Gather hardware overflow events into map positions.
    always_comb begin
        hw_ovf                = '0;
        hw_ovf[NCNT-1:0]      = ev_wrap;
        hw_ovf[CYC_BIT]       = cyc_wrap;
    end

    // Control register storage; reset-style bits are pulses and are not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_e  <= 1'b0;
            ctrl_d  <= 1'b0;
            ctrl_x  <= 1'b0;
            ctrl_dp <= 1'b0;
        end else if (wr && rk == RK_CTRL) begin
            ctrl_e  <= w32[CTL_EN];
            ctrl_d  <= w32[CTL_DIV];
            ctrl_x  <= w32[CTL_EXP];
            ctrl_dp <= w32[CTL_DPR];
        end
    end

    // Count-enable map through its set and clear views.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnten <= '0;
        else if (wr && rk == RK_CNTSET) cnten <= cnten | (w32 & MAP_MASK);
        else if (wr && rk == RK_CNTCLR) cnten <= cnten & ~w32;
    end

    // Interrupt-enable map through its set and clear views.
    always_ff @(posedge clk) begin
        if (!rst_n)                    inten <= '0;
        else if (wr && rk == RK_INTSET) inten <= inten | (w32 & MAP_MASK);
        else if (wr && rk == RK_INTCLR) inten <= inten & ~w32;
    end

    // Overflow flags: software set/clear, then hardware wraps on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovs <= '0;
        end else begin
            ovs <= ((ovs | ((wr && rk == RK_OVSSET) ? (w32 & MAP_MASK) : 32'd0))
                    & ~((wr && rk == RK_OVSCLR) ? w32 : 32'd0)) | hw_ovf;
        end
    end

    // Counter select, user-enable and filter storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            uen_q  <= '0;
            filt_q <= '0;
        end else if (wr) begin
            if (rk == RK_SEL)  sel_q  <= w32[4:0];
            if (rk == RK_UEN)  uen_q  <= w32[3:0];
            if (rk == RK_FILT) filt_q <= w32[31:26];
        end
    end

    // Read multiplexer over every register kind.
    always_comb begin
        rmux = '0;
        case (rk)
            RK_CTRL:   rmux = 64'({NCNT5, 5'd0, ctrl_dp, ctrl_x, ctrl_d, 2'b00, ctrl_e});
            RK_CNTSET,
            RK_CNTCLR: rmux = {32'd0, cnten};
            RK_INTSET,
            RK_INTCLR: rmux = {32'd0, inten};
            RK_OVSSET,
            RK_OVSCLR: rmux = {32'd0, ovs};
            RK_SEL:    rmux = {59'd0, sel_q};
            RK_CEID0:  rmux = {32'd0, CEID0};
            RK_CEID1:  rmux = {32'd0, CEID1};
            RK_CCNT:   rmux = acc_wide ? ccnt : {32'd0, ccnt[31:0]};
            RK_EVCNT:  rmux = {32'd0, cnt_arr[ri]};
            RK_EVTYP:  rmux = {32'd0, typ_arr[ri]};
            RK_UEN:    rmux = {60'd0, uen_q};
            RK_FILT:   rmux = {32'd0, filt_q, 26'd0};
            default:   rmux = '0;
        endcase
    end

    assign rd_data = (acc_valid && !acc_write) ? rmux : 64'd0;
    assign ovf_irq = |(ovs & inten);

endmodule

// File: rtl/pmu_regbank_chk.sv
// Property checker for the performance counter register bank, bound onto every instance.
// Assumes the names of the top's internal state; it only observes.
module pmu_regbank_chk
    import pmu_pkg::*;
#(
    parameter int NCNT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_wide,
    input  reg_kind_e          rk,
    input  logic [4:0]         ri,
    input  logic [63:0]        acc_wdata,
    input  logic [31:0]        cnten,
    input  logic [31:0]        ovs,
    input  logic               ctrl_e,
    input  logic [NCNT*32-1:0] cnt_flat,
    input  logic [63:0]        ccnt
);

    localparam logic [31:0] MAP_MASK = 32'h8000_0000 | ((32'd1 << NCNT) - 32'd1);

    logic wr;
    assign wr = acc_valid && acc_write;

    // R2
    cnten_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rk == RK_CNTSET) |=>
        ((cnten & $past(acc_wdata[31:0]) & MAP_MASK) == ($past(acc_wdata[31:0]) & MAP_MASK)));

    // R2
    cnten_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rk == RK_CNTCLR) |=> ((cnten & $past(acc_wdata[31:0])) == 32'd0));

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ovs) & ~ovs)) |-> $past(wr && rk == RK_OVSCLR));

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_e && !wr) |=> $stable(cnt_flat));

    // R8
    oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rk == RK_EVCNT && int'(ri) >= NCNT && !ctrl_e) |=> $stable(cnt_flat));

    // R9
    ccnt_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rk == RK_CCNT && !acc_wide) |=>
        (ccnt[63:32] == $past(ccnt[63:32]) && ccnt[31:0] == $past(acc_wdata[31:0])));

endmodule

bind pmu_regbank pmu_regbank_chk #(.NCNT(NCNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_wide  (acc_wide),
    .rk        (rk),
    .ri        (ri),
    .acc_wdata (acc_wdata),
    .cnten     (cnten),
    .ovs       (ovs),
    .ctrl_e    (ctrl_e),
    .cnt_flat  (cnt_flat),
    .ccnt      (ccnt)
);

// File: tb/tb_pmu_regbank.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_pmu_regbank;

    localparam int NCNT = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic            acc_write = 1'b0;
    logic            acc_wide = 1'b0;
    logic [3:0]      acc_crn = '0;
    logic [3:0]      acc_crm = '0;
    logic [2:0]      acc_op2 = '0;
    logic [2:0]      acc_op1 = '0;
    logic [63:0]     acc_wdata = '0;
    logic [NCNT-1:0] evt_pulse = '0;
    logic [63:0]     rd_data;
    logic            ovf_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pmu_regbank #(.NCNT(NCNT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_wide  (acc_wide),
        .acc_crn   (acc_crn),
        .acc_crm   (acc_crm),
        .acc_op2   (acc_op2),
        .acc_op1   (acc_op1),
        .acc_wdata (acc_wdata),
        .evt_pulse (evt_pulse),
        .rd_data   (rd_data),
        .ovf_irq   (ovf_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] op2,
                      input logic [63:0] data, input logic wide = 1'b0, input logic [2:0] op1 = 3'd0);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_wide = wide;
        acc_crn = crn; acc_crm = crm; acc_op2 = op2; acc_op1 = op1; acc_wdata = data;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0; acc_wide = 1'b0; acc_op1 = 3'd0;
    endtask

    task automatic rd(input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] op2,
                      output logic [63:0] d, input logic wide = 1'b0, input logic [2:0] op1 = 3'd0);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_wide = wide;
        acc_crn = crn; acc_crm = crm; acc_op2 = op2; acc_op1 = op1;
        #1 d = rd_data;
        #1 acc_valid = 1'b0; acc_wide = 1'b0; acc_op1 = 3'd0;
    endtask

    task automatic rd_cnt(input int n, output logic [63:0] d);
        rd(4'd14, 4'(8 + n / 8), 3'(n % 8), d);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd(9, 12, 0, d); chk("R1 ctrl", d, 64'h3000);
        rd(9, 12, 1, d); chk("R1 cnten", d, 0);
        rd(9, 14, 3, d); chk("R1 ovf", d, 0);
        rd(9, 14, 0, d); chk("R1 uen", d, 0);
        rd(14, 15, 7, d); chk("R1 filter", d, 0);
        rd_cnt(0, d);    chk("R1 counter0", d, 0);
        rd(9, 13, 0, d, 1'b1); chk("R1 cycle", d, 0);
        chk("R1 irq", 64'(ovf_irq), 0);
        rd(9, 12, 1, d); acc_valid = 1'b0; #1 chk("R13 idle rd_data", rd_data, 0);
    endtask

    task automatic t_maps();
        logic [63:0] d;
        wr(9, 12, 1, 64'hFFFF_FFFF);
        rd(9, 12, 1, d); chk("R2 cnten set view", d, 64'h8000_003F);
        wr(9, 12, 2, 64'h8000_0001);
        rd(9, 12, 2, d); chk("R2 cnten clear view", d, 64'h3E);
        wr(9, 12, 2, 64'hFFFF_FFFF);
        rd(9, 12, 1, d); chk("R2 cnten cleared", d, 0);
        wr(9, 14, 1, 64'h5);
        wr(9, 14, 2, 64'h4);
        rd(9, 14, 1, d); chk("R2 inten after set/clear", d, 64'h1);
        wr(9, 14, 1, 64'h0);
        rd(9, 14, 2, d); chk("R2 inten write zero no effect", d, 64'h1);
        wr(9, 14, 2, 64'hFFFF_FFFF);
    endtask

    task automatic t_events();
        logic [63:0] d;
        wr(9, 12, 1, 64'h4);
        @(negedge clk); evt_pulse = 6'b010100;
        repeat (3) @(negedge clk);
        evt_pulse = '0;
        rd_cnt(2, d); chk("R4 counter2 held while disabled", d, 0);
        wr(9, 12, 0, 64'h1);
        @(negedge clk); evt_pulse = 6'b010100;
        repeat (5) @(negedge clk);
        evt_pulse = '0;
        rd_cnt(2, d); chk("R4 counter2 five pulses", d, 5);
        rd_cnt(4, d); chk("R4 counter4 not enabled", d, 0);
        wr(9, 12, 0, 64'h3);
        rd(9, 12, 0, d); chk("R11 ctrl reads E only", d, 64'h3001);
        rd_cnt(2, d); chk("R11 event reset bit", d, 0);
        wr(9, 12, 0, 64'h38);
        rd(9, 12, 0, d); chk("R11 stored bits 3..5", d, 64'h3038);
        wr(9, 12, 0, 64'h0);
        wr(9, 12, 2, 64'hFFFF_FFFF);
    endtask

    task automatic t_swinc();
        logic [63:0] d;
        wr(9, 12, 1, 64'h1);
        wr(9, 12, 0, 64'h1);
        wr(9, 12, 4, 64'h3);
        rd_cnt(0, d); chk("R5 swinc enabled counter", d, 1);
        rd_cnt(1, d); chk("R5 swinc disabled counter", d, 0);
        @(negedge clk);
        evt_pulse = 6'b000001;
        acc_valid = 1'b1; acc_write = 1'b1; acc_crn = 9; acc_crm = 12; acc_op2 = 4; acc_wdata = 64'h1;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0; evt_pulse = '0;
        rd_cnt(0, d); chk("R5 swinc plus pulse", d, 3);
        wr(9, 12, 0, 64'h0);
        wr(9, 12, 4, 64'h1);
        rd_cnt(0, d); chk("R5 swinc with global enable off", d, 3);
        rd(9, 12, 4, d); chk("R5 swinc reads zero", d, 0);
        wr(9, 12, 2, 64'hFFFF_FFFF);
    endtask

    task automatic t_overflow();
        logic [63:0] d;
        wr(9, 12, 0, 64'h1);
        wr(9, 12, 1, 64'h8);
        wr(9, 12, 5, 64'h3);
        wr(9, 13, 2, 64'hFFFF_FFFF);
        rd(9, 13, 2, d); chk("R6 indirect counter read", d, 64'hFFFF_FFFF);
        rd_cnt(3, d);    chk("R7 direct counter3", d, 64'hFFFF_FFFF);
        wr(9, 12, 4, 64'h8);
        rd_cnt(3, d);    chk("R3 counter wrapped", d, 0);
        rd(9, 14, 3, d); chk("R3 ovf set view", d, 64'h8);
        rd(9, 12, 3, d); chk("R3 ovf clear view", d, 64'h8);
        chk("R3 irq masked", 64'(ovf_irq), 0);
        wr(9, 14, 1, 64'h8);
        chk("R3 irq raised", 64'(ovf_irq), 1);
        wr(9, 14, 3, 64'h1);
        rd(9, 12, 3, d); chk("R3 ovf software set", d, 64'h9);
        wr(9, 12, 3, 64'h9);
        rd(9, 14, 3, d); chk("R3 ovf cleared", d, 0);
        chk("R3 irq dropped", 64'(ovf_irq), 0);
        wr(9, 14, 2, 64'hFFFF_FFFF);
        wr(9, 12, 0, 64'h0);
        wr(9, 12, 2, 64'hFFFF_FFFF);
    endtask

    task automatic t_select();
        logic [63:0] d;
        wr(14, 12, 2, 64'hFFFF_FFFF);
        rd(14, 12, 2, d); chk("R12 type width direct", d, 64'h3FF);
        wr(9, 12, 5, 64'h2);
        rd(9, 12, 5, d); chk("R6 select readback", d, 64'h2);
        rd(9, 13, 1, d); chk("R6 indirect type", d, 64'h3FF);
        wr(9, 12, 5, 64'h9);
        wr(9, 13, 2, 64'h55);
        rd(9, 13, 2, d); chk("R8 indirect out of range", d, 0);
        rd(9, 13, 1, d); chk("R8 indirect type out of range", d, 0);
        wr(14, 8, 7, 64'h77);
        rd(14, 8, 7, d); chk("R8 direct out of range", d, 0);
        wr(14, 9, 1, 64'h12);
        rd_cnt(1, d); chk("R7 direct n=9 does not alias n=1", d, 0);
    endtask

    task automatic t_misc();
        logic [63:0] d;
        wr(14, 15, 7, 64'hFFFF_FFFF);
        rd(14, 15, 7, d); chk("R12 filter bits", d, 64'hFC00_0000);
        wr(9, 14, 0, 64'hFF);
        rd(9, 14, 0, d); chk("R12 user enable bits", d, 64'hF);
        rd(9, 12, 0, d, 1'b0, 3'd1); chk("R13 op1 nonzero read", d, 0);
        wr(9, 12, 1, 64'h1, 1'b0, 3'd2);
        rd(9, 12, 1, d); chk("R13 op1 nonzero write ignored", d, 0);
        rd(9, 15, 0, d); chk("R13 unmapped read", d, 0);
        rd(9, 12, 6, d); chk("R13 id word 0", d, 64'h6000_1F3B);
        rd(9, 12, 7, d); chk("R13 id word 1", d, 64'hA5);
    endtask

    task automatic t_cycle();
        logic [63:0] d;
        wr(9, 12, 1, 64'h8000_0000);
        wr(9, 13, 0, 64'h0000_0001_FFFF_FFFE, 1'b1);
        rd(9, 13, 0, d, 1'b1); chk("R9 wide read", d, 64'h0000_0001_FFFF_FFFE);
        rd(9, 13, 0, d);       chk("R9 narrow read", d, 64'hFFFF_FFFE);
        wr(9, 13, 0, 64'hAAAA_AAAA_0000_0010);
        rd(9, 13, 0, d, 1'b1); chk("R9 narrow write keeps upper", d, 64'h0000_0001_0000_0010);
        wr(9, 12, 0, 64'h1);
        repeat (4) @(posedge clk);
        wr(9, 12, 0, 64'h0);
        rd(9, 13, 0, d, 1'b1); chk("R10 counted five edges", d, 64'h0000_0001_0000_0015);
        wr(9, 13, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        wr(9, 12, 0, 64'h1);
        wr(9, 12, 0, 64'h0);
        rd(9, 13, 0, d, 1'b1); chk("R10 64-bit wrap", d, 0);
        rd(9, 14, 3, d);       chk("R10 cycle overflow flag", d, 64'h8000_0000);
        wr(9, 12, 3, 64'h8000_0000);
        wr(9, 12, 0, 64'hD);
        repeat (130) @(posedge clk);
        wr(9, 12, 0, 64'h0);
        rd(9, 13, 0, d, 1'b1); chk("R10 divided count", d, 2);
        wr(9, 12, 0, 64'h4);
        rd(9, 13, 0, d, 1'b1); chk("R11 cycle reset bit", d, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_maps();
        t_events();
        t_swinc();
        t_overflow();
        t_select();
        t_misc();
        t_cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule